// File: doc/BRIEF.md
# Dword-Granular Qword Reassembler

This block sits on the receive side of a device that takes 48-byte messages, six 8-byte words, written by a host into a 64-byte aligned window. The host stores whole 8-byte words, but the link may deliver them as memory writes that start on any 4-byte boundary. A write may carry partial byte enables on its first and last dword, and one 8-byte word may be split across two separate writes. Writes may also arrive in any address order, so a message can have holes for a while.

The block accepts writes on a valid/ready beat stream. Each write supplies a dword address, a length in dwords and two byte-enable masks on its first beat. Each 64-bit beat carries two consecutive dwords of the write. Every enabled byte is merged into a staging line, and a per-byte valid map records which bytes are present. When an aligned 8-byte word becomes complete, its bit in a done vector pulses. When all 48 bytes are present, a message-ready pulse presents the whole line, and the map is cleared for the next message. Three counters track all writes received, writes that start off an 8-byte boundary, and writes that were dropped.

Top module: `qword_reassembler`

## Requirements
- R1: A write may start at any dword address. Beat k of a write carries write-relative dword 2k in bits 31:0 and dword 2k+1 in bits 63:32, and its unused upper half is ignored.
- R2: The first dword of a write uses inFirstBe, the last dword uses inLastBe, and the dwords between use all four bytes. A one-dword write uses inFirstBe only and ignores inLastBe. Bit b of a mask enables byte b of its dword, which is data bits 8b+7:8b.
- R3: Dword address A, byte b maps to message byte 4*(A-WIN_BASE)+b. Message word w is bytes 8w to 8w+7 and appears on msgData bits 64w+63:64w.
- R4: Bit w of wordDone pulses for one cycle, in the cycle after the beat that makes word w fully valid, and only once per message.
- R5: msgReady pulses for one cycle, in the cycle after the beat that makes all 48 bytes valid, with msgData holding the merged message. inReady is low in that cycle, and the next message starts from an empty valid map.
- R6: A write whose address lies outside the window, or that would reach past byte 47, or that has length zero, has all its beats consumed without merging anything, and dropCount increases by one.
- R7: A beat that writes a byte already valid in the current message pulses overlapHit in the next cycle, and the newer byte replaces the older one.
- R8: wrCount increases by one for every write received. unalignedCount increases by one for every write whose dword address is odd.
- R9: Halves of a word written in separate writes, and words written out of ascending order, assemble into the same message as a single ordered write would.
- R10: After reset, inReady is high, wordDone, msgReady and overlapHit are low, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat valid |
| inReady | output | 1 | Beat accepted when high together with inValid |
| inAddr | input | ADDR_W | Dword address of the write, sampled on its first beat |
| inLen | input | LEN_W | Write length in dwords, sampled on its first beat |
| inFirstBe | input | 4 | Byte enables of the first dword |
| inLastBe | input | 4 | Byte enables of the last dword |
| inData | input | 64 | Two dwords of write data |
| msgData | output | 64*MSG_WORDS | Staging line, one byte per message byte |
| wordDone | output | MSG_WORDS | Per-word completion pulse |
| msgReady | output | 1 | Whole-message completion pulse |
| overlapHit | output | 1 | Pulse when a beat rewrote an already-valid byte |
| wrCount | output | CNT_W | Writes received |
| unalignedCount | output | CNT_W | Writes starting off an 8-byte boundary |
| dropCount | output | CNT_W | Writes dropped |

## Verification
The hardest case to reach is a single 8-byte word whose two halves come from different writes. One half arrives with an odd dword address in a multi-beat write. The other arrives later as a lone dword, while other words already have holes. If the logic merges per word instead of per byte, it fails only here. The stimulus builds this directly: first a lone odd dword, then its even partner, then a nine-dword write that starts on an odd dword, and last a single dword that closes the final hole. Separate sequences use partial enables on both ends of a write, and a one-dword write whose unused last mask is full. They also send dropped writes that would otherwise have merged, and then check that a following full message shows neither overlap nor their data.

// File: rtl/qwr_pkg.sv
package qwr_pkg;

  // Merge commands from control to datapath for one accepted beat
  typedef struct packed {
    logic       mergeLo;   // low dword of the beat is merged
    logic       mergeHi;   // high dword of the beat is merged
    logic [3:0] dwLo;      // window dword index of the low dword
    logic [3:0] dwHi;      // window dword index of the high dword
    logic [3:0] beLo;      // byte enables applied to the low dword
    logic [3:0] beHi;      // byte enables applied to the high dword
    logic       clearLine; // empty the valid map
  } qwr_strobe_t;

endpackage

// File: rtl/qwr_ctrl.sv
module qwr_ctrl
  import qwr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 5,
  parameter int CNT_W = 16,
  parameter int MSG_DW = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [3:0]        inFirstBe,
  input  logic [3:0]        inLastBe,
  input  logic              msgReady,
  output qwr_strobe_t       strobe,
  output logic [CNT_W-1:0]  wrCount,
  output logic [CNT_W-1:0]  unalignedCount,
  output logic [CNT_W-1:0]  dropCount
);

  logic              busyQ, dropQ;
  logic [LEN_W-1:0]  remQ;
  logic [3:0]        offQ;
  logic [3:0]        lastBeQ;
  logic [CNT_W-1:0]  wrCntQ, unalCntQ, dropCntQ;

  logic              accept, headBeat, inWin, fits, curDrop, hasHi;
  logic [LEN_W:0]    endOff;
  logic [LEN_W-1:0]  curRem;
  logic [3:0]        curOff, curLastBe;

  always_comb begin
    inReady   = ~msgReady;
    accept    = inValid & inReady;
    headBeat  = ~busyQ;
    inWin     = (inAddr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
    endOff    = {1'b0, inLen} + (LEN_W+1)'(inAddr[3:0]);
    fits      = (inLen != '0) && (endOff <= (LEN_W+1)'(MSG_DW));
    curDrop   = headBeat ? !(inWin && fits) : dropQ;
    curRem    = headBeat ? inLen : remQ;
    curOff    = headBeat ? inAddr[3:0] : offQ;
    curLastBe = headBeat ? inLastBe : lastBeQ;
    hasHi     = (curRem >= LEN_W'(2));

    strobe.mergeLo   = accept & ~curDrop;
    strobe.mergeHi   = accept & ~curDrop & hasHi;
    strobe.dwLo      = curOff;
    strobe.dwHi      = curOff + 4'd1;
    strobe.beLo      = headBeat ? inFirstBe :
                       ((curRem == LEN_W'(1)) ? curLastBe : 4'hF);
    strobe.beHi      = (curRem == LEN_W'(2)) ? curLastBe : 4'hF;
    strobe.clearLine = msgReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      dropQ    <= 1'b0;
      remQ     <= '0;
      offQ     <= '0;
      lastBeQ  <= '0;
      wrCntQ   <= '0;
      unalCntQ <= '0;
      dropCntQ <= '0;
    end else if (accept) begin
      busyQ   <= (curRem > LEN_W'(2));
      remQ    <= curRem - LEN_W'(2);
      offQ    <= curOff + 4'd2;
      dropQ   <= curDrop;
      lastBeQ <= curLastBe;
      if (headBeat) begin
        wrCntQ <= wrCntQ + 1'b1;
        if (inAddr[0]) unalCntQ <= unalCntQ + 1'b1;
        if (curDrop)   dropCntQ <= dropCntQ + 1'b1;
      end
    end
  end

  assign wrCount        = wrCntQ;
  assign unalignedCount = unalCntQ;
  assign dropCount      = dropCntQ;

  // R8: the write counter advances by at most one per cycle
  p_wr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wrCntQ == $past(wrCntQ)) || (wrCntQ == $past(wrCntQ) + 1'b1));

  // R8, R6: the sub-counters never run ahead of the write counter
  p_sub_le_r8: assert property (@(posedge clk) disable iff (!rstN)
    (unalCntQ <= wrCntQ) && (dropCntQ <= wrCntQ));

  // R6: a dropped write merges nothing on any of its later beats
  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && dropQ) |-> !(strobe.mergeLo || strobe.mergeHi));

endmodule

// File: rtl/qwr_datapath.sv
module qwr_datapath
  import qwr_pkg::*;
#(
  parameter int MSG_WORDS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  qwr_strobe_t            strobe,
  input  logic [63:0]            inData,
  output logic [64*MSG_WORDS-1:0] msgData,
  output logic [MSG_WORDS-1:0]   wordDone,
  output logic                   msgReady,
  output logic                   overlapHit
);

  localparam int MSG_BYTES = MSG_WORDS * 8;
  localparam int MSG_DW    = MSG_WORDS * 2;

  logic [MSG_BYTES-1:0] mapQ, wrMask, nextMap;
  logic [7:0]           lineQ  [MSG_BYTES];
  logic [7:0]           wrByte [MSG_BYTES];
  logic [MSG_WORDS-1:0] wordFullOld, wordFullNew, wordDoneQ;
  logic                 msgReadyQ, overlapQ;

  always_comb begin
    for (int d = 0; d < MSG_DW; d++) begin
      for (int b = 0; b < 4; b++) begin
        logic selLo, selHi;
        selLo = strobe.mergeLo && (strobe.dwLo == 4'(d)) && strobe.beLo[b];
        selHi = strobe.mergeHi && (strobe.dwHi == 4'(d)) && strobe.beHi[b];
        wrMask[4*d+b] = selLo | selHi;
        wrByte[4*d+b] = selHi ? inData[32+8*b +: 8] : inData[8*b +: 8];
      end
    end
    nextMap = mapQ | wrMask;
  end

  for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
    assign wordFullOld[w] = &mapQ[8*w +: 8];
    assign wordFullNew[w] = &nextMap[8*w +: 8];
  end

  for (genvar i = 0; i < MSG_BYTES; i++) begin : g_byte
    assign msgData[8*i +: 8] = lineQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapQ      <= '0;
      wordDoneQ <= '0;
      msgReadyQ <= 1'b0;
      overlapQ  <= 1'b0;
    end else if (strobe.clearLine) begin
      mapQ      <= '0;
      wordDoneQ <= '0;
      msgReadyQ <= 1'b0;
      overlapQ  <= 1'b0;
    end else begin
      mapQ      <= nextMap;
      wordDoneQ <= wordFullNew & ~wordFullOld;
      msgReadyQ <= &nextMap;
      overlapQ  <= |(mapQ & wrMask);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MSG_BYTES; i++) begin
      if (wrMask[i]) lineQ[i] <= wrByte[i];
    end
  end

  assign wordDone   = wordDoneQ;
  assign msgReady   = msgReadyQ;
  assign overlapHit = overlapQ;

  // R4: a done pulse only names words whose bytes are all valid
  p_done_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordDoneQ & ~wordFullOld) == '0);

  // R4: no word reports done in two consecutive cycles
  p_done_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordDoneQ != '0) |=> ((wordDoneQ & $past(wordDoneQ)) == '0));

  // R5: message-ready lasts one cycle and leaves an empty map behind
  p_msg_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    msgReadyQ |=> (!msgReadyQ && (mapQ == '0)));

  // R5: nothing is merged while the full line is being presented
  p_no_merge_r5: assert property (@(posedge clk) disable iff (!rstN)
    msgReadyQ |-> !(strobe.mergeLo || strobe.mergeHi));

endmodule

// File: rtl/qword_reassembler.sv
module qword_reassembler
  import qwr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 5,
  parameter int CNT_W = 16,
  parameter int MSG_WORDS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic [LEN_W-1:0]        inLen,
  input  logic [3:0]              inFirstBe,
  input  logic [3:0]              inLastBe,
  input  logic [63:0]             inData,
  output logic [64*MSG_WORDS-1:0] msgData,
  output logic [MSG_WORDS-1:0]    wordDone,
  output logic                    msgReady,
  output logic                    overlapHit,
  output logic [CNT_W-1:0]        wrCount,
  output logic [CNT_W-1:0]        unalignedCount,
  output logic [CNT_W-1:0]        dropCount
);

  localparam int MSG_DW = MSG_WORDS * 2;

  qwr_strobe_t strobe;

  qwr_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .MSG_DW(MSG_DW), .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inLen(inLen), .inFirstBe(inFirstBe),
    .inLastBe(inLastBe), .msgReady(msgReady), .strobe(strobe),
    .wrCount(wrCount), .unalignedCount(unalignedCount),
    .dropCount(dropCount)
  );

  qwr_datapath #(.MSG_WORDS(MSG_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .msgData(msgData), .wordDone(wordDone), .msgReady(msgReady),
    .overlapHit(overlapHit)
  );

  // R5: no beat is taken in the cycle the full message is shown
  p_no_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    msgReady |-> !(inValid && inReady));

endmodule

// File: tb/qword_reassembler_bench.sv
module qword_reassembler_bench;

  localparam logic [15:0] BASE = 16'h0040;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [15:0]  inAddr = '0;
  logic [4:0]   inLen = '0;
  logic [3:0]   inFirstBe = '0;
  logic [3:0]   inLastBe = '0;
  logic [63:0]  inData = '0;
  logic [383:0] msgData;
  logic [5:0]   wordDone;
  logic         msgReady, overlapHit;
  logic [15:0]  wrCount, unalignedCount, dropCount;

  always #2 clk = ~clk;

  qword_reassembler u_qword_reassembler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inLen(inLen), .inFirstBe(inFirstBe),
    .inLastBe(inLastBe), .inData(inData), .msgData(msgData),
    .wordDone(wordDone), .msgReady(msgReady), .overlapHit(overlapHit),
    .wrCount(wrCount), .unalignedCount(unalignedCount),
    .dropCount(dropCount)
  );

  typedef struct {
    logic [5:0]   wd;
    logic         mr;
    logic         ov;
    logic [383:0] data;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, fails = 0;
  int expWr = 0, expUnal = 0, expDrop = 0;
  int seed = 0;
  bit       mMap  [48];
  logic [7:0] mData [48];

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [5:0] fullWords();
    logic [5:0] r;
    for (int w = 0; w < 6; w++) begin
      r[w] = 1'b1;
      for (int b = 0; b < 8; b++) if (!mMap[8*w+b]) r[w] = 1'b0;
    end
    return r;
  endfunction

  // Driver: sends one write and pushes the events the requirements predict
  task automatic sendWrite(input logic [15:0] addr, input int len,
                           input logic [3:0] fbe, input logic [3:0] lbe,
                           input string tag);
    int  nBeats, off;
    bit  drop;
    nBeats = (len == 0) ? 1 : (len + 1) / 2;
    off    = int'(addr[3:0]);
    drop   = !((addr[15:4] == BASE[15:4]) && (len >= 1) && (off + len <= 12));
    expWr++;                            // R8
    if (addr[0]) expUnal++;             // R8
    if (drop) expDrop++;                // R6
    for (int k = 0; k < nBeats; k++) begin
      exp_t       e;
      logic [5:0] wdOld, wdNew;
      logic [63:0] beat;
      bit         ov, all;
      @(negedge clk);
      while (!inReady) @(negedge clk);
      seed++;
      beat = {32'(seed * 32'h9E3779B1), 32'(seed * 32'h85EBCA6B) ^ 32'h5A5A1234};
      inValid = 1'b1;
      inAddr = addr; inLen = 5'(len); inFirstBe = fbe; inLastBe = lbe;
      inData = beat;
      wdOld = fullWords();
      ov = 1'b0;
      for (int l = 0; l < 2; l++) begin
        int i;
        logic [3:0] be;
        i = 2 * k + l;
        if (i < len && !drop) begin
          be = (i == 0) ? fbe : ((i == len - 1) ? lbe : 4'hF);   // R2
          for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
              int p;
              p = (off + i) * 4 + b;                              // R3
              if (mMap[p]) ov = 1'b1;                             // R7
              mMap[p] = 1'b1;
              mData[p] = beat[32*l + 8*b +: 8];                   // R1
            end
          end
        end
      end
      wdNew = fullWords();
      all = (wdNew == 6'h3F);
      e.wd = wdNew & ~wdOld; e.mr = all; e.ov = ov; e.tag = tag;
      e.data = '0;
      if (all) begin
        for (int p = 0; p < 48; p++) begin
          e.data[8*p +: 8] = mData[p];
          mMap[p] = 1'b0;
        end
      end
      if (e.wd != 0 || e.mr || e.ov) expQ.push_back(e);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: compares every observed event against the scoreboard
  always @(negedge clk) begin
    if (rstN && (wordDone != 0 || msgReady || overlapHit)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, $sformatf("R4 unexpected event: actual wd=%h mr=%b ov=%b, expected none",
                            wordDone, msgReady, overlapHit));
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(wordDone == e.wd && msgReady == e.mr && overlapHit == e.ov,
            $sformatf("%s events: actual wd=%h mr=%b ov=%b, expected wd=%h mr=%b ov=%b",
                      e.tag, wordDone, msgReady, overlapHit, e.wd, e.mr, e.ov));
        if (e.mr)
          chk(msgData == e.data,
              $sformatf("%s data: actual %h, expected %h", e.tag, msgData, e.data));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 48; p++) begin mMap[p] = 1'b0; mData[p] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(inReady == 1'b1, $sformatf("R10 inReady: actual %b, expected 1", inReady));
    chk(wordDone == 0 && !msgReady && !overlapHit,
        $sformatf("R10 pulses: actual wd=%h mr=%b ov=%b, expected 0 0 0",
                  wordDone, msgReady, overlapHit));
    chk(wrCount == 0 && unalignedCount == 0 && dropCount == 0,
        $sformatf("R10 counters: actual %0d %0d %0d, expected 0 0 0",
                  wrCount, unalignedCount, dropCount));

    // R5, R3, R1: whole message in one write
    sendWrite(BASE, 12, 4'hF, 4'hF, "R5 whole");

    // R9: qword stores with words 3 and 4 swapped
    sendWrite(BASE + 0, 2, 4'hF, 4'hF, "R9 reorder");
    sendWrite(BASE + 2, 2, 4'hF, 4'hF, "R9 reorder");
    sendWrite(BASE + 4, 2, 4'hF, 4'hF, "R9 reorder");
    sendWrite(BASE + 8, 2, 4'hF, 4'hF, "R9 reorder");
    sendWrite(BASE + 6, 2, 4'hF, 4'hF, "R9 reorder");
    sendWrite(BASE + 10, 2, 4'hF, 4'hF, "R9 reorder");

    // R1, R9: halves of words in separate writes, odd start addresses
    sendWrite(BASE + 1, 1, 4'hF, 4'h0, "R1 upper half");
    sendWrite(BASE + 0, 1, 4'hF, 4'h0, "R9 lower half");
    sendWrite(BASE + 3, 9, 4'hF, 4'hF, "R1 odd multi-beat");
    sendWrite(BASE + 2, 1, 4'hF, 4'h0, "R9 fill hole");

    // R2: partial first/last enables, single-dword write ignores last mask
    sendWrite(BASE + 1, 3, 4'b1110, 4'b0111, "R2 edge masks");
    sendWrite(BASE + 3, 1, 4'h0, 4'hF, "R2 single ignores last");
    sendWrite(BASE + 0, 1, 4'hF, 4'h0, "R2 fill dword0");
    sendWrite(BASE + 1, 1, 4'b0001, 4'h0, "R2 fill byte4");
    sendWrite(BASE + 3, 1, 4'b1000, 4'h0, "R2 fill byte15");
    sendWrite(BASE + 4, 8, 4'hF, 4'hF, "R2 fill rest");

    // R7: rewrite of word 0, newer data kept
    sendWrite(BASE + 0, 2, 4'hF, 4'hF, "R7 first");
    sendWrite(BASE + 0, 2, 4'hF, 4'hF, "R7 overlap");
    sendWrite(BASE + 2, 10, 4'hF, 4'hF, "R7 rest");

    // R6: dropped writes leave no trace in the next message
    sendWrite(16'h0080, 2, 4'hF, 4'hF, "R6 outside window");
    sendWrite(BASE + 11, 2, 4'hF, 4'hF, "R6 past end");
    sendWrite(BASE + 4, 0, 4'hF, 4'hF, "R6 zero length");
    sendWrite(BASE, 12, 4'hF, 4'hF, "R6 after drops");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0,
        $sformatf("R4 missing events: actual %0d left, expected 0", expQ.size()));
    chk(wrCount == 16'(expWr),
        $sformatf("R8 wrCount: actual %0d, expected %0d", wrCount, expWr));
    chk(unalignedCount == 16'(expUnal),
        $sformatf("R8 unalignedCount: actual %0d, expected %0d", unalignedCount, expUnal));
    chk(dropCount == 16'(expDrop),
        $sformatf("R6 dropCount: actual %0d, expected %0d", dropCount, expDrop));
    chk(inReady == 1'b1, $sformatf("R5 inReady idle: actual %b, expected 1", inReady));

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule